// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between the operand-address logic of an 8-bit core and the storage behind it. An access either names a 7-bit file offset inside the bank held by a 5-bit bank-select register, or it goes through a 16-bit indirect pointer. The mapper sorts every access into one of four data regions. The first is a small set of core registers that every bank reaches at the same offsets. The second is a per-bank window of peripheral registers. The third is per-bank general-purpose RAM. The fourth is a 16-byte common area that is the same physical storage from every bank. For the two RAM regions it produces one linear address into a single packed RAM.

When the top bit of the pointer is set, an indirect read goes to program memory instead. The mapper issues a program-memory request whose address wraps inside the implemented program space. In the following cycle it raises an extra-cycle flag, because the core needs one more cycle to take the low byte of the fetched word. Indirect writes aimed at program memory are dropped.

General-purpose RAM that lies beyond the implemented banks is unimplemented, and so is any data-space pointer with bits above the 12-bit data space set. Nothing is selected for such a location. A read of one raises a flag that tells the datapath to return zero. A write to one has no effect at all. All outputs are registered and follow the request by one clock.

Top module: `dmem_route`

## Requirements
- R1: An access at offsets 0x00..0x0B in any bank asserts `sel_core` with `core_idx` equal to the offset, whatever the bank.
- R2: An access at offsets 0x0C..0x1F asserts `sel_periph` with `periph_addr` = {bank[4:0], offset[4:0]}.
- R3: An access at offsets 0x20..0x6F in bank b < GPR_BANKS asserts `sel_ram` with `ram_addr` = b*80 + (offset - 0x20).
- R4: An access at offsets 0x70..0x7F in any bank asserts `sel_ram` with `ram_addr` = GPR_BANKS*80 + (offset - 0x70), so all banks reach the same 16 bytes.
- R5: An unimplemented location selects nothing, and `acc_we` stays low. A read there raises `rd_zero`. Unimplemented locations are offsets 0x20..0x6F in a bank >= GPR_BANKS, and pointer values with bit 15 clear and any of bits 14..12 set.
- R6: With `use_ptr` high and ptr[15] clear, the bank is ptr[11:7] and the offset is ptr[6:0]. `bank_sel` and `dir_ofs` are ignored.
- R7: With `use_ptr` high, ptr[15] set and `rd_en` high, `pm_req` is asserted with `pm_addr` = ptr modulo PM_WORDS, and no data region is selected.
- R8: `pm_xcyc` is high exactly in the cycle that follows a cycle with `pm_req` high.
- R9: An indirect write with ptr[15] set and `rd_en` low produces no select, no `acc_we` and no `pm_req`.
- R10: With neither `rd_en` nor `wr_en`, every select, `acc_we`, `pm_req` and `rd_zero` is low.
- R11: After reset every output is zero.
- R12: Outputs reflect the inputs of the previous clock edge. `acc_we` is high when a data region is selected and `wr_en` was high. Fields that belong to an unselected region read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| use_ptr | input | 1 | Take the address from `ptr` instead of bank/offset |
| bank_sel | input | 5 | Bank-select register value |
| dir_ofs | input | 7 | Direct file offset from the instruction |
| ptr | input | 16 | Indirect pointer value |
| sel_core | output | 1 | Core register region selected |
| sel_periph | output | 1 | Peripheral register region selected |
| sel_ram | output | 1 | General-purpose or common RAM selected |
| acc_we | output | 1 | Selected data access is a write |
| core_idx | output | 4 | Core register index |
| periph_addr | output | 10 | Bank and window offset of the peripheral register |
| ram_addr | output | RAM_AW | Linear address into the packed RAM |
| pm_req | output | 1 | Program-memory read request |
| pm_addr | output | PM_AW | Program-memory word address |
| pm_xcyc | output | 1 | Extra cycle for the program-memory read |
| rd_zero | output | 1 | Read of an unimplemented location, data must be zero |

## Verification
Every cycle, the assertions check the following. At most one of the three data selects and the program request is high. An unimplemented read never drives a select. The extra-cycle flag pairs exactly with the request before it. An idle cycle or a program-memory write produces nothing. Any direct access to the core or common range lands where it must in every bank. The bench scenarios are needed for the exact linear RAM address of each bank, the peripheral bank/offset packing, the pointer taking over from the bank register, and the wrap of program addresses. They are also needed for the boundary offsets 0x0B/0x0C, 0x1F/0x20, 0x6F/0x70 and 0x7F, and for the first bank without general-purpose RAM.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int BANK_W       = 5;
    localparam int OFS_W        = 7;
    localparam int PTR_W        = 16;
    localparam int CORE_LO      = 'h00;
    localparam int PERIPH_LO    = 'h0C;
    localparam int GPR_LO       = 'h20;
    localparam int COMMON_LO    = 'h70;
    localparam int GPR_BYTES    = COMMON_LO - GPR_LO;
    localparam int COMMON_BYTES = (1 << OFS_W) - COMMON_LO;
    localparam int CORE_IDX_W   = 4;
    localparam int PWIN_W       = 5;
    localparam int PERIPH_AW    = BANK_W + PWIN_W;
    localparam int DSPACE_W     = BANK_W + OFS_W;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CORE,
        RG_PERIPH,
        RG_GPR,
        RG_COMMON
    } region_e;

endpackage

// File: rtl/dmem_ptr_dec.sv
module dmem_ptr_dec
    import dmem_pkg::*;
#(
    parameter int PM_AW = 12
) (
    input  logic                use_ptr,
    input  logic [PTR_W-1:0]    ptr,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic [OFS_W-1:0]    dir_ofs,
    output logic [BANK_W-1:0]   eff_bank,
    output logic [OFS_W-1:0]    eff_ofs,
    output logic                is_pm,
    output logic                ptr_bad,
    output logic [PM_AW-1:0]    pm_addr
);

    logic [PTR_W-2-DSPACE_W:0] hi_bits;

    always_comb begin
        hi_bits  = ptr[PTR_W-2:DSPACE_W];
        is_pm    = use_ptr & ptr[PTR_W-1];
        ptr_bad  = use_ptr & ~ptr[PTR_W-1] & (|hi_bits);
        pm_addr  = ptr[PM_AW-1:0];
        if (use_ptr) begin
            eff_bank = ptr[DSPACE_W-1:OFS_W];
            eff_ofs  = ptr[OFS_W-1:0];
        end else begin
            eff_bank = bank_sel;
            eff_ofs  = dir_ofs;
        end
    end

endmodule

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
    import dmem_pkg::*;
#(
    parameter int GPR_BANKS = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  ofs,
    output region_e           region
);

    always_comb begin
        if (int'(ofs) < PERIPH_LO) begin
            region = RG_CORE;
        end else if (int'(ofs) < GPR_LO) begin
            region = RG_PERIPH;
        end else if (int'(ofs) < COMMON_LO) begin
            region = (int'(bank) < GPR_BANKS) ? RG_GPR : RG_NONE;
        end else begin
            region = RG_COMMON;
        end
    end

endmodule

// File: rtl/dmem_ram_addr.sv
module dmem_ram_addr
    import dmem_pkg::*;
#(
    parameter int GPR_BANKS = 3,
    parameter int RAM_AW    = 8
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  ofs,
    input  region_e           region,
    output logic [RAM_AW-1:0] ram_addr
);

    localparam int COMMON_BASE = GPR_BANKS * GPR_BYTES;

    int lin;

    always_comb begin
        case (region)
            RG_GPR:    lin = int'(bank) * GPR_BYTES + int'(ofs) - GPR_LO;
            RG_COMMON: lin = COMMON_BASE + int'(ofs) - COMMON_LO;
            default:   lin = 0;
        endcase
        ram_addr = RAM_AW'(lin);
    end

endmodule

// File: rtl/dmem_route.sv
module dmem_route
    import dmem_pkg::*;
#(
    parameter  int GPR_BANKS = 3,
    parameter  int PM_WORDS  = 4096,
    localparam int RAM_WORDS = GPR_BANKS * GPR_BYTES + COMMON_BYTES,
    localparam int RAM_AW    = $clog2(RAM_WORDS),
    localparam int PM_AW     = $clog2(PM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic                  use_ptr,
    input  logic [BANK_W-1:0]     bank_sel,
    input  logic [OFS_W-1:0]      dir_ofs,
    input  logic [PTR_W-1:0]      ptr,
    output logic                  sel_core,
    output logic                  sel_periph,
    output logic                  sel_ram,
    output logic                  acc_we,
    output logic [CORE_IDX_W-1:0] core_idx,
    output logic [PERIPH_AW-1:0]  periph_addr,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  pm_req,
    output logic [PM_AW-1:0]      pm_addr,
    output logic                  pm_xcyc,
    output logic                  rd_zero
);

    typedef struct packed {
        logic                  sel_core;
        logic                  sel_periph;
        logic                  sel_ram;
        logic                  acc_we;
        logic [CORE_IDX_W-1:0] core_idx;
        logic [PERIPH_AW-1:0]  periph_addr;
        logic [RAM_AW-1:0]     ram_addr;
        logic                  pm_req;
        logic [PM_AW-1:0]      pm_addr;
        logic                  pm_xcyc;
        logic                  rd_zero;
    } route_s;

    route_s st_d, st_q;

    logic [BANK_W-1:0] eff_bank;
    logic [OFS_W-1:0]  eff_ofs;
    logic              is_pm;
    logic              ptr_bad;
    logic [PM_AW-1:0]  pm_addr_w;
    region_e           region;
    logic [RAM_AW-1:0] ram_addr_w;

    dmem_ptr_dec #(.PM_AW(PM_AW)) u_ptr (
        .use_ptr  (use_ptr),
        .ptr      (ptr),
        .bank_sel (bank_sel),
        .dir_ofs  (dir_ofs),
        .eff_bank (eff_bank),
        .eff_ofs  (eff_ofs),
        .is_pm    (is_pm),
        .ptr_bad  (ptr_bad),
        .pm_addr  (pm_addr_w)
    );

    dmem_region_dec #(.GPR_BANKS(GPR_BANKS)) u_reg (
        .bank   (eff_bank),
        .ofs    (eff_ofs),
        .region (region)
    );

    dmem_ram_addr #(.GPR_BANKS(GPR_BANKS), .RAM_AW(RAM_AW)) u_ram (
        .bank     (eff_bank),
        .ofs      (eff_ofs),
        .region   (region),
        .ram_addr (ram_addr_w)
    );

    // Next-state: all fields zero unless the decoded access claims them.
    always_comb begin
        st_d         = '0;
        st_d.pm_xcyc = st_q.pm_req;
        if (rd_en || wr_en) begin
            if (is_pm) begin
                if (rd_en) begin
                    st_d.pm_req  = 1'b1;
                    st_d.pm_addr = pm_addr_w;
                end
            end else if (ptr_bad || region == RG_NONE) begin
                st_d.rd_zero = rd_en;
            end else begin
                st_d.acc_we = wr_en;
                case (region)
                    RG_CORE: begin
                        st_d.sel_core = 1'b1;
                        st_d.core_idx = eff_ofs[CORE_IDX_W-1:0];
                    end
                    RG_PERIPH: begin
                        st_d.sel_periph  = 1'b1;
                        st_d.periph_addr = {eff_bank, eff_ofs[PWIN_W-1:0]};
                    end
                    default: begin
                        st_d.sel_ram  = 1'b1;
                        st_d.ram_addr = ram_addr_w;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_core    = st_q.sel_core;
    assign sel_periph  = st_q.sel_periph;
    assign sel_ram     = st_q.sel_ram;
    assign acc_we      = st_q.acc_we;
    assign core_idx    = st_q.core_idx;
    assign periph_addr = st_q.periph_addr;
    assign ram_addr    = st_q.ram_addr;
    assign pm_req      = st_q.pm_req;
    assign pm_addr     = st_q.pm_addr;
    assign pm_xcyc     = st_q.pm_xcyc;
    assign rd_zero     = st_q.rd_zero;

endmodule

// File: rtl/dmem_route_chk.sv
module dmem_route_chk
    import dmem_pkg::*;
#(
    parameter int GPR_BANKS = 3,
    parameter int RAM_AW    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic                  use_ptr,
    input logic [OFS_W-1:0]      dir_ofs,
    input logic [PTR_W-1:0]      ptr,
    input logic                  sel_core,
    input logic                  sel_periph,
    input logic                  sel_ram,
    input logic                  acc_we,
    input logic [CORE_IDX_W-1:0] core_idx,
    input logic [RAM_AW-1:0]     ram_addr,
    input logic                  pm_req,
    input logic                  pm_xcyc,
    input logic                  rd_zero
);

    localparam int COMMON_BASE = GPR_BANKS * GPR_BYTES;

    // R5: at most one target per cycle
    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_core, sel_periph, sel_ram, pm_req}));

    // R5: a zero-read never selects storage
    p_zero_no_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> !(sel_core || sel_periph || sel_ram || acc_we || pm_req));

    // R8: extra cycle follows each program request
    p_xcyc_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req |=> pm_xcyc);

    // R8: extra cycle only after a request
    p_xcyc_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_xcyc) |-> $past(pm_req));

    // R9: program-memory write is dropped
    p_pm_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && use_ptr && ptr[PTR_W-1])
        |=> !(pm_req || sel_core || sel_periph || sel_ram || acc_we || rd_zero));

    // R10: idle cycle produces nothing
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en)
        |=> !(pm_req || sel_core || sel_periph || sel_ram || acc_we || rd_zero));

    // R1: direct core offsets in any bank
    p_core_any_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !use_ptr && int'(dir_ofs) < PERIPH_LO)
        |=> (sel_core && core_idx == $past(dir_ofs[CORE_IDX_W-1:0])));

    // R4: direct common offsets in any bank reach the shared bytes
    p_common_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !use_ptr && int'(dir_ofs) >= COMMON_LO)
        |=> (sel_ram && int'(ram_addr) == COMMON_BASE + int'($past(dir_ofs)) - COMMON_LO));

    // R12: write flag follows the write strobe of a selected access
    p_we_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> ($past(wr_en) && (sel_core || sel_periph || sel_ram)));

endmodule

bind dmem_route dmem_route_chk #(.GPR_BANKS(GPR_BANKS), .RAM_AW(RAM_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .use_ptr    (use_ptr),
    .dir_ofs    (dir_ofs),
    .ptr        (ptr),
    .sel_core   (sel_core),
    .sel_periph (sel_periph),
    .sel_ram    (sel_ram),
    .acc_we     (acc_we),
    .core_idx   (core_idx),
    .ram_addr   (ram_addr),
    .pm_req     (pm_req),
    .pm_xcyc    (pm_xcyc),
    .rd_zero    (rd_zero)
);

// File: tb/test_dmem_route.sv
module test_dmem_route;

    localparam int GB     = 3;
    localparam int RAM_AW = 8;
    localparam int PM_AW  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, use_ptr = 1'b0;
    logic [4:0]  bank_sel = '0;
    logic [6:0]  dir_ofs = '0;
    logic [15:0] ptr = '0;

    logic              sel_core, sel_periph, sel_ram, acc_we, pm_req, pm_xcyc, rd_zero;
    logic [3:0]        core_idx;
    logic [9:0]        periph_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic [PM_AW-1:0]  pm_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    dmem_route i_dmem_route (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .use_ptr(use_ptr),
        .bank_sel(bank_sel), .dir_ofs(dir_ofs), .ptr(ptr),
        .sel_core(sel_core), .sel_periph(sel_periph), .sel_ram(sel_ram), .acc_we(acc_we),
        .core_idx(core_idx), .periph_addr(periph_addr), .ram_addr(ram_addr),
        .pm_req(pm_req), .pm_addr(pm_addr), .pm_xcyc(pm_xcyc), .rd_zero(rd_zero)
    );

    // expected outputs
    logic       e_core, e_per, e_ram, e_we, e_pm, e_xc, e_zero;
    logic [3:0] e_idx;
    logic [9:0] e_pa;
    int         e_ra;
    logic [PM_AW-1:0] e_pma;
    string      e_tag;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "sel_core", int'(sel_core), int'(e_core));
        chk(req, "sel_periph", int'(sel_periph), int'(e_per));
        chk(req, "sel_ram", int'(sel_ram), int'(e_ram));
        chk(req, "acc_we", int'(acc_we), int'(e_we));
        chk(req, "core_idx", int'(core_idx), int'(e_idx));
        chk(req, "periph_addr", int'(periph_addr), int'(e_pa));
        chk(req, "ram_addr", int'(ram_addr), e_ra);
        chk(req, "pm_req", int'(pm_req), int'(e_pm));
        chk(req, "pm_addr", int'(pm_addr), int'(e_pma));
        chk("R8", "pm_xcyc", int'(pm_xcyc), int'(e_xc));
        chk(req, "rd_zero", int'(rd_zero), int'(e_zero));
    endtask

    // Reference model built from the requirements
    task automatic predict(input logic rd, input logic wr, input logic up,
                           input logic [4:0] bk, input logic [6:0] of, input logic [15:0] p);
        logic [4:0] b;
        logic [6:0] o;
        e_xc = e_pm;  // R8
        e_core = 0; e_per = 0; e_ram = 0; e_we = 0; e_pm = 0; e_zero = 0;
        e_idx = 0; e_pa = 0; e_ra = 0; e_pma = 0; e_tag = "R10";
        if (!(rd || wr)) return;
        if (up && p[15]) begin
            e_tag = rd ? "R7" : "R9";
            if (rd) begin e_pm = 1; e_pma = p[PM_AW-1:0]; end
            return;
        end
        b = up ? p[11:7] : bk;
        o = up ? p[6:0] : of;
        if ((up && p[14:12] != 0) || (o >= 7'h20 && o < 7'h70 && int'(b) >= GB)) begin
            e_tag = "R5"; e_zero = rd; return;
        end
        e_we = wr;
        if (o < 7'h0C) begin e_tag = "R1"; e_core = 1; e_idx = o[3:0]; end
        else if (o < 7'h20) begin e_tag = "R2"; e_per = 1; e_pa = {b, o[4:0]}; end
        else if (o < 7'h70) begin e_tag = "R3"; e_ram = 1; e_ra = int'(b) * 80 + int'(o) - 32; end
        else begin e_tag = "R4"; e_ram = 1; e_ra = GB * 80 + int'(o) - 112; end
        if (up) e_tag = {e_tag, "/R6"};
    endtask

    // Drive at falling edge, check the previous vector at the next falling edge (R12)
    task automatic step(input logic rd, input logic wr, input logic up,
                        input logic [4:0] bk, input logic [6:0] of, input logic [15:0] p);
        rd_en = rd; wr_en = wr; use_ptr = up; bank_sel = bk; dir_ofs = of; ptr = p;
        predict(rd, wr, up, bk, of, p);
        @(negedge clk);
        check_all({e_tag, "/R12"});
    endtask

    initial begin
        e_pm = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        e_xc = 0; predict(0, 0, 0, 0, 0, 0);
        check_all("R11");
        rst_n = 1'b1;
        @(negedge clk);
        e_pm = 0;

        // Directed corners
        step(1, 0, 0, 5'd0,  7'h00, 0);           // R1
        step(0, 1, 0, 5'd31, 7'h0B, 0);           // R1 any bank
        step(1, 0, 0, 5'd31, 7'h0C, 0);           // R2
        step(1, 1, 0, 5'd17, 7'h1F, 0);           // R2
        step(1, 0, 0, 5'd0,  7'h20, 0);           // R3
        step(0, 1, 0, 5'd2,  7'h6F, 0);           // R3 top
        step(1, 0, 0, 5'd3,  7'h20, 0);           // R5 first bank without RAM
        step(0, 1, 0, 5'd31, 7'h40, 0);           // R5 write ignored
        step(1, 0, 0, 5'd0,  7'h70, 0);           // R4
        step(1, 0, 0, 5'd29, 7'h7F, 0);           // R4 same bytes
        step(1, 0, 1, 5'd0,  7'h00, 16'h0F7F);    // R6 bank 30 offset 7F
        step(1, 0, 1, 5'd31, 7'h05, 16'h0120);    // R6 bank 2 offset 20
        step(1, 0, 1, 5'd0,  7'h00, 16'h1020);    // R5 pointer above data space
        step(1, 0, 1, 5'd0,  7'h00, 16'h8000);    // R7
        step(0, 0, 0, 5'd0,  7'h00, 0);           // R8 extra cycle, R10
        step(1, 0, 1, 5'd0,  7'h00, 16'hFFFF);    // R7 wrap
        step(1, 0, 1, 5'd0,  7'h00, 16'hB234);    // R7 back to back, R8
        step(0, 1, 1, 5'd0,  7'h00, 16'h8123);    // R9
        step(0, 0, 1, 5'd1,  7'h30, 16'h8123);    // R10

        // Random mix with fixed seed
        void'($urandom(32'd2718));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] k;
            logic [15:0] rp;
            k = 3'($urandom_range(0, 7));
            rp = 16'($urandom);
            if (k[1:0] == 2'd1) rp[14:12] = 3'($urandom_range(0, 7) < 6 ? 0 : 1);
            step(1'($urandom), 1'($urandom), (k < 3), 5'($urandom), 7'($urandom), rp);
        end
        step(0, 0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule